// File: doc/BRIEF.md
# Faulted-Leg Locator with Redundant-Leg Switchover

This block runs after an open-circuit fault has been confirmed in a three-phase impedance-source inverter. That inverter produces three shoot-through intervals per half switching period, and each interval is made by a different phase leg. For a window of switching cycles the block receives a stored record per cycle: how many falling edges were captured on the digitised leg voltage, the first two capture timestamps, and the three expected falling-edge times. It also receives the current space-vector sector and a tolerance in timer ticks.

For each cycle with exactly two captures, the block works out which expected edge has no matching capture. It then maps that edge to a phase leg through a table that depends on the sector. The votes from all cycles are counted. If one leg holds a majority of the window, the block reports that leg, turns off that leg's gate commands and enables the spare leg. If no leg holds a majority, it reports an undetermined code and leaves the leg switching as it was.

The window is scanned one stored cycle per clock. The result therefore appears a fixed number of clocks after the start pulse.

Top module: `faulted_leg_locator`

## Requirements
- R1: After reset, `failed_leg` is 0 (undetermined), `done` is 0, `leg_disable` is 000 and `redundant_en` is 0.
- R2: Every difference is an absolute value in ticks. For a cycle, the first edge counts as missing when |cap1 − fe1| exceeds the margin. This holds whichever of the two times is larger.
- R3: The second edge counts as missing only when |cap1 − fe2| and |cap2 − fe2| both exceed the margin.
- R4: The third edge counts as missing when |cap2 − fe3| exceeds the margin.
- R5: A cycle in which none of the three missing-edge conditions holds, or more than one holds, is inconclusive and casts no vote.
- R6: Only window slots whose capture count equals 2 are evaluated. Every other slot casts no vote.
- R7: Leg codes are a=1, b=2, c=3. The edge-to-leg mapping is: sectors 1 and 4 map edges 1/2/3 to a/b/c; sectors 2 and 5 map them to c/a/b; sectors 3 and 6 map them to b/c/a.
- R8: A sector value of 0 or 7 makes every slot inconclusive.
- R9: A leg wins when its votes reach NCYC/2+1, counted over all NCYC window slots (3 of 5 by default). Otherwise the result is undetermined, including a tied split.
- R10: A winning leg is shown on `failed_leg`. `leg_disable` then holds exactly one set bit (bit0=a, bit1=b, bit2=c), and `redundant_en` is 1.
- R11: An undetermined result drives `failed_leg` to 0 and leaves `leg_disable` and `redundant_en` unchanged.
- R12: When a start is taken at a clock edge, `done` falls at that edge and rises NCYC+2 edges later, one edge after the decision. `done` then stays high until the next start.
- R13: The comparison with the margin is strict. A difference equal to the margin does not count as exceeding it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse to begin locating; taken when not busy |
| sector | input | 3 | Space-vector sector, 1..6 |
| margin | input | TW | Delay tolerance in timer ticks |
| win_ncap | input | NCYC*CW | Capture count per window slot |
| win_cap1 | input | NCYC*TW | First capture time per slot |
| win_cap2 | input | NCYC*TW | Second capture time per slot |
| win_fe1 | input | NCYC*TW | Expected first edge time per slot |
| win_fe2 | input | NCYC*TW | Expected second edge time per slot |
| win_fe3 | input | NCYC*TW | Expected third edge time per slot |
| failed_leg | output | 2 | 0 undetermined, 1 a, 2 b, 3 c |
| done | output | 1 | Result valid, held until next start |
| leg_disable | output | 3 | Gate-command inhibit per leg |
| redundant_en | output | 1 | Spare leg enable |

## Verification
The hardest cases to reach are the ones where a decision rests on only part of the window: some votes count, some slots are inconclusive, and others are skipped because the capture count is wrong. A ballot of this kind can land just above or just below the majority threshold, or end in a tie. The stimulus builds each window slot by slot from capture patterns with known distances, so that it produces exactly these vote mixes. It also moves the margin to within one tick of an error term, so that a single comparison decides the outcome. An undetermined run is placed directly after a decided one, which shows at the outputs that the earlier switchover is kept.

// File: rtl/fll_pkg.sv
package fll_pkg;
  typedef enum logic [1:0] {
    LEG_NONE = 2'd0,
    LEG_A    = 2'd1,
    LEG_B    = 2'd2,
    LEG_C    = 2'd3
  } leg_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_EVAL   = 2'd1,
    ST_DECIDE = 2'd2,
    ST_REPORT = 2'd3
  } st_t;
endpackage

// File: rtl/fll_absdiff.sv
module fll_absdiff #(
  parameter int TW = 16
) (
  input  logic [TW-1:0] a,
  input  logic [TW-1:0] b,
  output logic [TW-1:0] mag
);
  logic [TW:0] d;

  always_comb begin
    d = {1'b0, a} - {1'b0, b};
    if (d[TW]) mag = (~d[TW-1:0]) + TW'(1);
    else       mag = d[TW-1:0];
  end
endmodule

// File: rtl/fll_edge_judge.sv
module fll_edge_judge #(
  parameter int TW = 16,
  parameter int CW = 2
) (
  input  logic [CW-1:0] ncap,
  input  logic [TW-1:0] cap1,
  input  logic [TW-1:0] cap2,
  input  logic [TW-1:0] fe1,
  input  logic [TW-1:0] fe2,
  input  logic [TW-1:0] fe3,
  input  logic [TW-1:0] margin,
  output logic          hit,
  output logic [1:0]    edge_idx
);
  localparam int NERR = 4;

  logic [TW-1:0] opa [NERR];
  logic [TW-1:0] opb [NERR];
  logic [TW-1:0] err [NERR];
  logic          gone1, gone2, gone3, two;

  assign opa[0] = cap1;  assign opb[0] = fe1;
  assign opa[1] = cap1;  assign opb[1] = fe2;
  assign opa[2] = cap2;  assign opb[2] = fe2;
  assign opa[3] = cap2;  assign opb[3] = fe3;

  for (genvar k = 0; k < NERR; k++) begin : g_err
    fll_absdiff #(.TW(TW)) u_abs (.a(opa[k]), .b(opb[k]), .mag(err[k]));
  end

  always_comb begin
    gone1 = err[0] > margin;
    gone2 = (err[1] > margin) && (err[2] > margin);
    gone3 = err[3] > margin;
    two   = (ncap == CW'(2));
    hit   = two && $onehot({gone3, gone2, gone1});
    if (gone1)      edge_idx = 2'd0;
    else if (gone2) edge_idx = 2'd1;
    else            edge_idx = 2'd2;
  end
endmodule

// File: rtl/fll_leg_map.sv
module fll_leg_map
  import fll_pkg::*;
(
  input  logic [2:0] sector,
  input  logic [1:0] edge_idx,
  input  logic       hit,
  output leg_t       leg
);
  logic       sec_ok;
  logic [2:0] rot;
  logic [2:0] sum;
  logic [2:0] idx;

  always_comb begin
    sec_ok = (sector >= 3'd1) && (sector <= 3'd6);
    rot    = (sector >= 3'd4) ? (sector - 3'd4) : (sector - 3'd1);
    sum    = {1'b0, edge_idx} + 3'd3 - rot;
    idx    = (sum >= 3'd3) ? (sum - 3'd3) : sum;
    if (!hit || !sec_ok) leg = LEG_NONE;
    else begin
      case (idx)
        3'd0:    leg = LEG_A;
        3'd1:    leg = LEG_B;
        default: leg = LEG_C;
      endcase
    end
  end
endmodule

// File: rtl/faulted_leg_locator.sv
module faulted_leg_locator
  import fll_pkg::*;
#(
  parameter int NCYC = 5,
  parameter int TW   = 16,
  parameter int CW   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        sector,
  input  logic [TW-1:0]     margin,
  input  logic [NCYC*CW-1:0] win_ncap,
  input  logic [NCYC*TW-1:0] win_cap1,
  input  logic [NCYC*TW-1:0] win_cap2,
  input  logic [NCYC*TW-1:0] win_fe1,
  input  logic [NCYC*TW-1:0] win_fe2,
  input  logic [NCYC*TW-1:0] win_fe3,
  output logic [1:0]        failed_leg,
  output logic              done,
  output logic [2:0]        leg_disable,
  output logic              redundant_en
);
  localparam int CNTW  = $clog2(NCYC + 1);
  localparam int IW    = (NCYC > 2) ? $clog2(NCYC) : 1;
  localparam int MAJ   = NCYC / 2 + 1;
  localparam int NLEG  = 3;

  st_t            state;
  logic [IW-1:0]  idx;
  logic [CNTW-1:0] cnt [NLEG];
  logic [CW-1:0]  cur_ncap;
  logic [TW-1:0]  cur_cap1, cur_cap2, cur_fe1, cur_fe2, cur_fe3;
  logic           slot_hit;
  logic [1:0]     slot_edge;
  leg_t           slot_leg;
  leg_t           winner;
  logic           take;

  assign take = start && (state == ST_IDLE);

  always_comb begin
    cur_ncap = win_ncap[idx*CW +: CW];
    cur_cap1 = win_cap1[idx*TW +: TW];
    cur_cap2 = win_cap2[idx*TW +: TW];
    cur_fe1  = win_fe1[idx*TW +: TW];
    cur_fe2  = win_fe2[idx*TW +: TW];
    cur_fe3  = win_fe3[idx*TW +: TW];
  end

  fll_edge_judge #(.TW(TW), .CW(CW)) u_judge (
    .ncap(cur_ncap), .cap1(cur_cap1), .cap2(cur_cap2),
    .fe1(cur_fe1), .fe2(cur_fe2), .fe3(cur_fe3),
    .margin(margin), .hit(slot_hit), .edge_idx(slot_edge)
  );

  fll_leg_map u_map (
    .sector(sector), .edge_idx(slot_edge), .hit(slot_hit), .leg(slot_leg)
  );

  for (genvar g = 0; g < NLEG; g++) begin : g_vote
    always_ff @(posedge clk) begin
      if (rst || take) cnt[g] <= '0;
      else if (state == ST_EVAL && slot_leg == leg_t'(g + 1)) cnt[g] <= cnt[g] + CNTW'(1);
    end

    // R9
    vote_bound_chk: assert property (@(posedge clk) disable iff (rst)
      cnt[g] <= CNTW'(NCYC));
  end

  always_comb begin
    winner = LEG_NONE;
    for (int g = 0; g < NLEG; g++)
      if (cnt[g] >= CNTW'(MAJ)) winner = leg_t'(g + 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      idx          <= '0;
      failed_leg   <= LEG_NONE;
      done         <= 1'b0;
      leg_disable  <= '0;
      redundant_en <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state      <= ST_EVAL;
            idx        <= '0;
            done       <= 1'b0;
            failed_leg <= LEG_NONE;
          end
        end
        ST_EVAL: begin
          idx <= idx + IW'(1);
          if (idx == IW'(NCYC - 1)) state <= ST_DECIDE;
        end
        ST_DECIDE: begin
          failed_leg <= winner;
          case (winner)
            LEG_A: begin leg_disable <= 3'b001; redundant_en <= 1'b1; end
            LEG_B: begin leg_disable <= 3'b010; redundant_en <= 1'b1; end
            LEG_C: begin leg_disable <= 3'b100; redundant_en <= 1'b1; end
            default: ;
          endcase
          state <= ST_REPORT;
        end
        default: begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
      endcase
    end
  end

  // R10
  disable_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(leg_disable));

  // R12
  done_latency_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(state, 2) == ST_DECIDE));

  // R11
  undet_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DECIDE && winner == LEG_NONE) |=>
      ($stable(leg_disable) && $stable(redundant_en) && failed_leg == 2'd0));

  // R6
  count_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EVAL && cur_ncap != CW'(2)) |-> (slot_leg == LEG_NONE));

  // R8
  bad_sector_chk: assert property (@(posedge clk) disable iff (rst)
    (sector == 3'd0 || sector == 3'd7) |-> (slot_leg == LEG_NONE));
endmodule

// File: tb/faulted_leg_locator_test.sv
`timescale 1ns/1ps
module faulted_leg_locator_test;
  localparam int NCYC = 5;
  localparam int TW   = 16;
  localparam int CW   = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [2:0] sector = 3'd1;
  logic [TW-1:0] margin = 16'd100;
  logic [NCYC*CW-1:0] win_ncap;
  logic [NCYC*TW-1:0] win_cap1, win_cap2, win_fe1, win_fe2, win_fe3;
  logic [1:0] failed_leg;
  logic done;
  logic [2:0] leg_disable;
  logic redundant_en;

  logic [CW-1:0] s_n [NCYC];
  logic [TW-1:0] s_c1 [NCYC], s_c2 [NCYC], s_f1 [NCYC], s_f2 [NCYC], s_f3 [NCYC];

  always_comb begin
    for (int k = 0; k < NCYC; k++) begin
      win_ncap[k*CW +: CW] = s_n[k];
      win_cap1[k*TW +: TW] = s_c1[k];
      win_cap2[k*TW +: TW] = s_c2[k];
      win_fe1[k*TW +: TW]  = s_f1[k];
      win_fe2[k*TW +: TW]  = s_f2[k];
      win_fe3[k*TW +: TW]  = s_f3[k];
    end
  end

  faulted_leg_locator #(.NCYC(NCYC), .TW(TW), .CW(CW)) uut (
    .clk(clk), .rst(rst), .start(start), .sector(sector), .margin(margin),
    .win_ncap(win_ncap), .win_cap1(win_cap1), .win_cap2(win_cap2),
    .win_fe1(win_fe1), .win_fe2(win_fe2), .win_fe3(win_fe3),
    .failed_leg(failed_leg), .done(done), .leg_disable(leg_disable),
    .redundant_en(redundant_en)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct {
    int    leg;
    int    dis;
    int    red;
    int    rise;
    string tag;
  } exp_t;
  exp_t sb [$];

  int model_dis = 0;
  int model_red = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // expected leg for one slot, from the requirement text
  function automatic int slot_vote(input int n, input int c1, input int c2,
                                   input int f1, input int f2, input int f3,
                                   input int m, input int s);
    bit g1, g2, g3;
    int e;
    if (n != 2) return 0;
    g1 = iabs(c1 - f1) > m;
    g2 = (iabs(c1 - f2) > m) && (iabs(c2 - f2) > m);
    g3 = iabs(c2 - f3) > m;
    if ((int'(g1) + int'(g2) + int'(g3)) != 1) return 0;
    e = g1 ? 1 : (g2 ? 2 : 3);
    case (s)
      1, 4: return e;
      2, 5: return (e == 1) ? 3 : ((e == 2) ? 1 : 2);
      3, 6: return (e == 1) ? 2 : ((e == 2) ? 3 : 1);
      default: return 0;
    endcase
  endfunction

  // kind: 1/2/3 = that edge missing, 0 = three captures, 4 = two conditions, 5 = one capture
  task automatic set_slot(input int k, input int kind);
    int b;
    b = 1000 + 37 * k;
    s_f1[k] = TW'(b);
    s_f2[k] = TW'(b + 1000);
    s_f3[k] = TW'(b + 2000);
    s_n[k]  = 2'd2;
    case (kind)
      1: begin s_c1[k] = TW'(b + 1005); s_c2[k] = TW'(b + 1993); end
      2: begin s_c1[k] = TW'(b + 3);    s_c2[k] = TW'(b + 2004); end
      3: begin s_c1[k] = TW'(b - 6);    s_c2[k] = TW'(b + 1008); end
      4: begin s_c1[k] = TW'(b + 1005); s_c2[k] = TW'(b + 1500); end
      5: begin s_c1[k] = TW'(b + 1005); s_c2[k] = '0; s_n[k] = 2'd1; end
      default: begin s_c1[k] = TW'(b + 2); s_c2[k] = TW'(b + 1003); s_n[k] = 2'd3; end
    endcase
  endtask

  task automatic run_case(input string tag, input int sec, input int m);
    int votes [4];
    int w;
    exp_t e;
    votes = '{0, 0, 0, 0};
    for (int k = 0; k < NCYC; k++)
      votes[slot_vote(int'(s_n[k]), int'(s_c1[k]), int'(s_c2[k]), int'(s_f1[k]),
                      int'(s_f2[k]), int'(s_f3[k]), m, sec)]++;
    w = 0;
    for (int l = 1; l <= 3; l++) if (votes[l] >= NCYC / 2 + 1) w = l;
    if (w != 0) begin
      model_dis = 1 << (w - 1);
      model_red = 1;
    end
    e.leg = w; e.dis = model_dis; e.red = model_red; e.tag = tag;
    @(negedge clk);
    sector = 3'(sec);
    margin = TW'(m);
    start  = 1'b1;
    e.rise = cyc + NCYC + 3;
    sb.push_back(e);
    @(negedge clk);
    start = 1'b0;
    repeat (NCYC + 5) @(negedge clk);
    // R12 done holds until the next start
    check(done === 1'b1, "R12 done held", int'(done), 1);
  endtask

  // monitor: pop the oldest expectation on each rising done
  logic prev_done = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && done && !prev_done) begin
        if (sb.size() == 0) begin
          check(1'b0, "R12 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(int'(failed_leg) == e.leg, {e.tag, " failed_leg"}, int'(failed_leg), e.leg);
          check(int'(leg_disable) == e.dis, {e.tag, " R10 leg_disable"}, int'(leg_disable), e.dis);
          check(int'(redundant_en) == e.red, {e.tag, " R10 redundant_en"}, int'(redundant_en), e.red);
          check(cyc == e.rise, "R12 done latency", cyc, e.rise);
        end
      end
      prev_done = done;
    end
  end

  initial begin
    fork
      begin
        for (int k = 0; k < NCYC; k++) set_slot(k, 0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(failed_leg == 2'd0, "R1 failed_leg", int'(failed_leg), 0);
        check(done == 1'b0, "R1 done", int'(done), 0);
        check(leg_disable == 3'd0, "R1 leg_disable", int'(leg_disable), 0);
        check(redundant_en == 1'b0, "R1 redundant_en", int'(redundant_en), 0);

        for (int k = 0; k < NCYC; k++) set_slot(k, 1);
        run_case("R2 R7 sec1 edge1", 1, 100);
        for (int k = 0; k < NCYC; k++) set_slot(k, 2);
        run_case("R3 sec4 edge2", 4, 100);
        for (int k = 0; k < NCYC; k++) set_slot(k, 3);
        run_case("R4 R7 sec2 edge3", 2, 100);
        for (int k = 0; k < NCYC; k++) set_slot(k, 1);
        run_case("R7 sec3 edge1", 3, 100);
        for (int k = 0; k < NCYC; k++) set_slot(k, 2);
        run_case("R7 sec6 edge2", 6, 100);
        for (int k = 0; k < NCYC; k++) set_slot(k, 1);
        run_case("R7 sec5 edge1", 5, 100);
        // two votes only: undetermined, previous switchover kept
        set_slot(0, 1); set_slot(1, 5); set_slot(2, 1); set_slot(3, 5); set_slot(4, 5);
        run_case("R11 R9 two votes", 1, 100);
        for (int k = 0; k < NCYC; k++) set_slot(k, 4);
        run_case("R5 double match", 1, 100);
        for (int k = 0; k < NCYC; k++) set_slot(k, 1);
        run_case("R8 sector0", 0, 100);
        run_case("R8 sector7", 7, 100);
        set_slot(0, 3); set_slot(1, 0); set_slot(2, 3); set_slot(3, 0); set_slot(4, 3);
        run_case("R6 R9 bare majority", 3, 100);
        for (int k = 0; k < NCYC; k++) set_slot(k, 1);
        run_case("R13 margin equal", 2, 1005);
        run_case("R13 margin below", 2, 1004);
        set_slot(0, 1); set_slot(1, 2); set_slot(2, 1); set_slot(3, 2); set_slot(4, 3);
        run_case("R9 tie", 1, 100);
        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R12 results missing", sb.size(), 0);
      end
      begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule